// File: doc/BRIEF.md
# ADC Serial Frame Port

This block is the digital side of the serial port of a 16-channel sampling converter. The host lowers chip select and clocks exactly sixteen serial clock periods. On each falling serial clock edge the block takes one bit from the data input, most significant bit first. On the same edges it presents a frame on the data output: a 4-bit channel tag, then a 12-bit conversion result. The sample that the frame reports is latched when chip select falls, and it is reported within that same frame with no pipeline delay.

Only the first twelve received bits form a control word. The word's leading bit decides whether the other eleven bits replace the stored configuration. The stored configuration sets the result coding for later conversions. It also sets whether the data output keeps being driven between frames. The stored configuration is also given out whole, for the sequencing and power blocks that sit next to this port. The block runs on a system clock and finds chip select and serial clock edges by comparing each input with its value one cycle earlier. The data output is split into a data pin and an output-enable pin, so that a pad cell can build the three-state or weakly driven line from them.

Top module: `adc_frame_port`

## Requirements
- R1: Out of reset the stored configuration `cfgWord` is all zeros, and while chip select is high `outEn` is 0.
- R2: After chip select falls, the k-th falling serial clock edge (k = 0 meaning the chip select edge itself) puts bit k of the frame on `dout`. The frame is the 4-bit channel tag, MSB first, followed by the 12-bit result, MSB first.
- R3: With `cfgWord[0]` (coding) at 1 the result is the sample unchanged (straight binary). With it at 0 the result is the sample with its MSB inverted (twos complement).
- R4: If the first received bit is 1, the twelfth falling edge copies received bits 2 to 12 into `cfgWord[10:0]`. The layout of `cfgWord` from bit 10 down to bit 0 is: sequence, channel address (4 bits), power mode (2 bits), shadow select, idle drive, range, coding.
- R5: If the first received bit is 0, the frame leaves `cfgWord` unchanged.
- R6: Bits received on falling edges 13 to 16 have no effect on `cfgWord`.
- R7: A frame that chip select ends before its twelfth falling edge leaves `cfgWord` unchanged, whatever bits it carried.
- R8: The sample and the channel tag are latched when chip select falls. Changing `sampleIn` or `chanTag` later in the frame does not alter the bits sent.
- R9: While a frame is active, `outEn` is 1. Between frames, if `cfgWord[2]` is 1 then `outEn` is 1 and `dout` equals `idleTagBit`; if it is 0 then `outEn` is 0.
- R10: A coding change written by a frame applies from the next frame onward. The frame that carries the write still reports its own result with the previous coding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Frame select, active low |
| sclk | input | 1 | Serial clock, idles high, data taken on falling edges |
| din | input | 1 | Serial control input |
| sampleIn | input | DATA_W | Conversion code, straight binary |
| chanTag | input | TAG_W | Channel of the conversion being reported |
| idleTagBit | input | 1 | Channel MSB of the next conversion, driven when idle |
| dout | output | 1 | Serial frame output data |
| outEn | output | 1 | Output enable for dout |
| cfgWord | output | 11 | Stored configuration |

## Verification
Two things happen on the twelfth falling edge. The configuration is committed there, and the same edge shifts a result bit out, a result that was already coded from the previous configuration. The bench writes frames that flip the coding bit. It then checks, through a queue of expected frames, that the frame carrying the write is still coded the old way and that the next frame uses the new coding. It also changes `sampleIn` in the middle of a frame, to show that the latched sample, not the live one, is what goes out.

// File: rtl/adc_frame_pkg.sv
package adc_frame_pkg;

  localparam int CTRL_LEN = 12;

  typedef struct packed {
    logic       seqOn;
    logic [3:0] chanAddr;
    logic [1:0] pwrMode;
    logic       shadowSel;
    logic       idleDrive;
    logic       rangeSel;
    logic       coding;
  } cfgReg_t;

  localparam int CFG_W = $bits(cfgReg_t);

  typedef struct packed {
    logic load;
    logic shift;
    logic capture;
    logic commit;
    logic active;
  } frameStrobe_t;

endpackage

// File: rtl/adc_frame_ctrl.sv
module adc_frame_ctrl
  import adc_frame_pkg::*;
#(
  parameter int FRAME_LEN = 16,
  parameter int WORD_LEN  = CTRL_LEN
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         csN,
  input  logic         sclk,
  output frameStrobe_t strb
);
  localparam int CNT_W = $clog2(FRAME_LEN + 1);

  logic             csPrev;
  logic             sclkPrev;
  logic             inFrameQ;
  logic [CNT_W-1:0] edgeCnt;
  logic             csFall;
  logic             sclkFall;

  assign csFall   = csPrev & ~csN;
  assign sclkFall = sclkPrev & ~sclk & ~csN & ~csFall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPrev   <= 1'b1;
      sclkPrev <= 1'b1;
      inFrameQ <= 1'b0;
      edgeCnt  <= '0;
    end else begin
      csPrev   <= csN;
      sclkPrev <= sclk;
      inFrameQ <= ~csN;
      if (csN || csFall)
        edgeCnt <= '0;
      else if (sclkFall && (edgeCnt < CNT_W'(FRAME_LEN)))
        edgeCnt <= edgeCnt + 1'b1;
    end
  end

  always_comb begin
    strb.load    = csFall;
    strb.shift   = sclkFall && (edgeCnt < CNT_W'(FRAME_LEN));
    strb.capture = sclkFall && (edgeCnt < CNT_W'(WORD_LEN));
    strb.commit  = sclkFall && (edgeCnt == CNT_W'(WORD_LEN - 1));
    strb.active  = inFrameQ;
  end
endmodule

// File: rtl/adc_frame_dp.sv
module adc_frame_dp
  import adc_frame_pkg::*;
#(
  parameter int TAG_W    = 4,
  parameter int DATA_W   = 12,
  parameter int WORD_LEN = CTRL_LEN
) (
  input  logic              clk,
  input  logic              rstN,
  input  frameStrobe_t      strb,
  input  logic              din,
  input  logic [DATA_W-1:0] sampleIn,
  input  logic [TAG_W-1:0]  chanTag,
  input  logic              idleTagBit,
  output logic              dout,
  output logic              outEn,
  output cfgReg_t           cfgQ
);
  localparam int FRAME_LEN = TAG_W + DATA_W;

  logic [FRAME_LEN-1:0] txShift;
  logic [WORD_LEN-2:0]  rxShift;
  logic [DATA_W-1:0]    codedRes;

  // twos complement from straight binary: flip the result MSB
  always_comb begin
    codedRes = sampleIn;
    if (!cfgQ.coding) codedRes[DATA_W-1] = ~sampleIn[DATA_W-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      cfgQ    <= '0;
    end else begin
      if (strb.load)
        txShift <= {chanTag, codedRes};
      else if (strb.shift)
        txShift <= {txShift[FRAME_LEN-2:0], 1'b0};

      if (strb.load)
        rxShift <= '0;
      else if (strb.capture)
        rxShift <= {rxShift[WORD_LEN-3:0], din};

      if (strb.commit && rxShift[WORD_LEN-2])
        cfgQ <= cfgReg_t'({rxShift[WORD_LEN-3:0], din});
    end
  end

  always_comb begin
    if (strb.active) begin
      dout  = txShift[FRAME_LEN-1];
      outEn = 1'b1;
    end else begin
      dout  = cfgQ.idleDrive & idleTagBit;
      outEn = cfgQ.idleDrive;
    end
  end
endmodule

// File: rtl/adc_frame_port.sv
module adc_frame_port
  import adc_frame_pkg::*;
#(
  parameter int TAG_W  = 4,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              din,
  input  logic [DATA_W-1:0] sampleIn,
  input  logic [TAG_W-1:0]  chanTag,
  input  logic              idleTagBit,
  output logic              dout,
  output logic              outEn,
  output logic [10:0]       cfgWord
);
  localparam int FRAME_LEN = TAG_W + DATA_W;

  frameStrobe_t strb;
  cfgReg_t      cfgQ;

  adc_frame_ctrl #(.FRAME_LEN(FRAME_LEN), .WORD_LEN(CTRL_LEN)) u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .strb(strb)
  );

  adc_frame_dp #(.TAG_W(TAG_W), .DATA_W(DATA_W), .WORD_LEN(CTRL_LEN)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .din(din), .sampleIn(sampleIn),
    .chanTag(chanTag), .idleTagBit(idleTagBit), .dout(dout), .outEn(outEn),
    .cfgQ(cfgQ)
  );

  assign cfgWord = cfgQ;
endmodule

// File: rtl/adc_frame_port_chk.sv
module adc_frame_port_chk (
  input logic        clk,
  input logic        rstN,
  input logic        csN,
  input logic        idleTagBit,
  input logic        dout,
  input logic        outEn,
  input logic [10:0] cfgWord
);
  assert_idle_tri_R9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(csN) && !cfgWord[2]) |-> !outEn);

  assert_idle_weak_R9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(csN) && cfgWord[2]) |-> (outEn && dout == idleTagBit));

  assert_frame_drive_R2: assert property (@(posedge clk) disable iff (!rstN)
    !$past(csN) |-> outEn);

  // R7: configuration can only move inside a frame
  assert_cfg_in_frame_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWord != $past(cfgWord)) |-> !$past(csN));
endmodule

bind adc_frame_port adc_frame_port_chk u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .idleTagBit(idleTagBit),
  .dout(dout), .outEn(outEn), .cfgWord(cfgWord)
);

// File: tb/tb_adc_frame_port.sv
module tb_adc_frame_port;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csN = 1'b1;
  logic        sclk = 1'b1;
  logic        din = 1'b0;
  logic [11:0] sampleIn = '0;
  logic [3:0]  chanTag = '0;
  logic        idleTagBit = 1'b0;
  logic        dout;
  logic        outEn;
  logic [10:0] cfgWord;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  logic [10:0] modelCfg = '0;
  logic [15:0] expQ[$];

  always #(CLK_P/2) clk = ~clk;

  adc_frame_port dut (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .din(din),
    .sampleIn(sampleIn), .chanTag(chanTag), .idleTagBit(idleTagBit),
    .dout(dout), .outEn(outEn), .cfgWord(cfgWord)
  );

  task automatic check(input bit ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: pushes the expected frame, then clocks it
  task automatic sendFrame(input logic [15:0] txWord, input logic [11:0] smp,
                           input logic [3:0] ch, input int nEdges);
    logic [11:0] coded;
    @(negedge clk);
    coded = modelCfg[0] ? smp : (smp ^ 12'h800);
    if (nEdges == 16) expQ.push_back({ch, coded});
    sampleIn = smp;
    chanTag  = ch;
    csN = 1'b0;
    #(2*CLK_P);
    sampleIn = ~smp;           // R8: later changes must not reach dout
    chanTag  = ~ch;
    for (int i = 0; i < nEdges; i++) begin
      din = txWord[15-i];
      #(2*CLK_P) sclk = 1'b0;
      #(4*CLK_P) sclk = 1'b1;
      #(2*CLK_P);
    end
    csN = 1'b1;
    #(4*CLK_P);
    if (nEdges >= 12 && txWord[15]) modelCfg = txWord[14:4];
  endtask

  task automatic checkCfg(input string req);
    check(cfgWord == modelCfg, req, {5'b0, cfgWord}, {5'b0, modelCfg});
  endtask

  // monitor: collects 16 bits per frame and compares against the queue
  initial begin
    forever begin
      logic [15:0] got;
      logic [15:0] exp;
      @(negedge csN);
      if (expQ.size() != 0) begin
        exp = expQ.pop_front();
        #(3*CLK_P);
        got[15] = dout;
        for (int k = 14; k >= 0; k--) begin
          @(negedge sclk);
          #(3*CLK_P);
          got[k] = dout;
        end
        check(got == exp, "R2/R3/R8/R10 frame content", got, exp);
      end
    end
  end

  initial begin
    #(CLK_P*200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(3*CLK_P + 2);
    check(cfgWord == 11'h0, "R1 reset cfgWord", {5'b0, cfgWord}, 16'h0);
    check(outEn == 1'b0, "R1 reset outEn", {15'b0, outEn}, 16'h0);
    rstN = 1'b1;
    #(3*CLK_P);

    // write: addr 5, pm 11, coding 1, weak 0; tail bits 1010 ignored (R6)
    // its own result still uses the reset coding 0 (R10)
    sendFrame({12'b1_0_0101_11_0_0_0_1, 4'b1010}, 12'h000, 4'h3, 16);
    checkCfg("R4 write commit");
    checkCfg("R6 tail bits ignored");
    check(outEn == 1'b0, "R9 idle tri", {15'b0, outEn}, 16'h0);

    // WRITE=0: nothing changes, coding 1 now in force
    sendFrame({12'b0_1_1111_00_1_1_1_0, 4'b1111}, 12'hFFF, 4'h9, 16);
    checkCfg("R5 write disabled");

    // enable idle drive, switch back to twos complement
    sendFrame({12'b1_1_1010_11_1_1_0_0, 4'b0000}, 12'h800, 4'hC, 16);
    checkCfg("R4 second write");
    idleTagBit = 1'b1;
    #(2*CLK_P);
    check(outEn && dout, "R9 weak drive high", {14'b0, outEn, dout}, 16'h3);
    idleTagBit = 1'b0;
    #(2*CLK_P);
    check(outEn && !dout, "R9 weak drive low", {14'b0, outEn, dout}, 16'h2);

    // aborted frames before the twelfth edge
    sendFrame({12'b1_0_0000_00_0_0_1_1, 4'b0000}, 12'h123, 4'h1, 8);
    checkCfg("R7 abort after 8");
    sendFrame({12'b1_0_0000_00_0_0_1_1, 4'b0000}, 12'h123, 4'h1, 11);
    checkCfg("R7 abort after 11");

    // result patterns under twos complement coding
    sendFrame({12'b0, 4'b0}, 12'h7FF, 4'hF, 16);
    sendFrame({12'b0, 4'b0}, 12'hA5C, 4'h6, 16);

    // exactly twelve edges commits: weak off, coding 1
    sendFrame({12'b1_0_0011_11_0_0_1_1, 4'b0000}, 12'h555, 4'h2, 12);
    checkCfg("R4 twelve edges commit");
    check(outEn == 1'b0, "R9 back to tri", {15'b0, outEn}, 16'h0);
    sendFrame({12'b0, 4'b0}, 12'h801, 4'hA, 16);
    sendFrame({12'b0, 4'b0}, 12'h3C3, 4'h0, 16);
    #(10*CLK_P);
    check(expQ.size() == 0, "R2 all frames seen", 16'(expQ.size()), 16'h0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule